// File: doc/BRIEF.md
# Split-Phase Receive Byte Clock Generator

This block sits behind a receive word aligner and turns its per-word strobe into two half-rate byte clocks for a downstream protocol device working with 10-bit bytes. One clock rises on the word positions 0 and 2 of the received sequence. The other is its exact complement, so it rises on positions 1 and 3. Every accepted word strobe flips both clocks together. A full period of either clock therefore covers two words.

The aligner raises a slip signal while it moves the word boundary. A slip blocks toggling, so during realignment a clock phase can only get longer. A minimum-phase guard counts fast-clock cycles since the last edge. It defers any strobe that would end a phase earlier than a configured number of cycles. The deferred toggle fires as soon as that minimum is met. When the mode input selects a parallel width other than 10 bits, both clocks park at a fixed level: 02-clock low and 13-clock high. The guard also applies to that parking step. Both outputs are driven straight from flip-flops.

Top module: `split_byte_clk`

## Requirements
- R1: While reset is asserted, and directly after it, `clkByte02` is 0 and `clkByte13` is 1.
- R2: At every clock after reset, `clkByte13` is the logical inverse of `clkByte02`.
- R3: With `tenBitMode`=1, `slip`=0 and strobes spaced at least `GAP_CYCLES` apart, each rising clock edge that samples `wordStb`=1 flips both outputs. The new levels are visible one cycle later.
- R4: No high or low phase of either output lasts fewer than `GAP_CYCLES` cycles. A strobe that comes too early is held as one pending toggle, and several early strobes merge into it. That toggle fires on the first edge at which `GAP_CYCLES` cycles have passed since the last edge.
- R5: On an edge that samples `slip`=1, neither output changes. Any pending toggle is discarded, so only a later strobe can move the clocks.
- R6: With `tenBitMode`=0, `wordStb` has no effect. If `clkByte02` is high, it is lowered once the R4 minimum is met. After that the outputs stay at `clkByte02`=0 and `clkByte13`=1.
- R7: After the outputs are parked, the first accepted strobe in 10-bit mode raises `clkByte02`, so word 0 is captured by its rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast recovered clock; all logic acts on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| tenBitMode | input | 1 | 1 selects the 10-bit parallel mode; 0 parks the byte clocks |
| wordStb | input | 1 | One-cycle pulse per valid output word from the aligner |
| slip | input | 1 | High while the aligner is shifting the word boundary |
| clkByte02 | output | 1 | Byte clock whose rising edges capture words 0 and 2 |
| clkByte13 | output | 1 | Complement byte clock; its rising edges capture words 1 and 3 |

## Verification
The bench sweeps the strobe spacing from one cycle up to well past the guard length. This catches a guard that lets a phase end early, because a too-short high or low run shows up at once. It also catches a guard that drops deferred toggles instead of firing them, because the clocks then fall out of step with the strobe count. A long pseudo-random stretch mixes slips, strobes and mode changes. A design that forgot to clear the pending toggle on a slip would move its clocks after a slip that should have held them. The bench also parks the outputs and then re-enters 10-bit mode. A design that parked at the wrong polarity would swap which clock captures word 0. A design that parked without the guard would cut a high phase short.

// File: rtl/split_byte_clk_pkg.sv
package split_byte_clk_pkg;

  // Strobes from control to datapath for one edge of the fast clock.
  typedef struct packed {
    logic advance;  // flip both byte clocks in 10-bit mode
    logic settle;   // drive both byte clocks to their parked levels
  } phase_cmd_t;

  localparam logic PARK_LEVEL_02 = 1'b0;

endpackage

// File: rtl/split_byte_clk_ctrl.sv
module split_byte_clk_ctrl
  import split_byte_clk_pkg::*;
#(
  parameter int GAP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tenBitMode,
  input  logic       wordStb,
  input  logic       slip,
  input  logic       phaseHigh,
  output phase_cmd_t cmd
);

  localparam int CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] GAP_VAL = CNT_W'(GAP_CYCLES);
  localparam logic [CNT_W-1:0] ONE_VAL = CNT_W'(1);

  logic [CNT_W-1:0] elapsed;
  logic             pending;
  logic             gapMet;
  logic             wantAdvance;
  logic             anyEdge;

  // Cycles since the last output edge, saturating at the guard length.
  assign gapMet      = (elapsed >= GAP_VAL);
  assign wantAdvance = tenBitMode && !slip && (wordStb || pending);

  always_comb begin
    cmd         = '0;
    cmd.advance = gapMet && wantAdvance;
    cmd.settle  = gapMet && !tenBitMode && (phaseHigh != PARK_LEVEL_02);
  end

  assign anyEdge = cmd.advance || cmd.settle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      elapsed <= GAP_VAL;
    end else if (anyEdge) begin
      elapsed <= ONE_VAL;
    end else if (!gapMet) begin
      elapsed <= elapsed + ONE_VAL;
    end
  end

  // One deferred toggle at most; slip or leaving 10-bit mode cancels it.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (!tenBitMode || slip) begin
      pending <= 1'b0;
    end else if (wantAdvance && !gapMet) begin
      pending <= 1'b1;
    end else if (cmd.advance) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/split_byte_clk_dp.sv
module split_byte_clk_dp
  import split_byte_clk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  phase_cmd_t cmd,
  output logic       clkByte02,
  output logic       clkByte13
);

  // Two separate registers, one per output pin, with no gating behind them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkByte02 <= PARK_LEVEL_02;
      clkByte13 <= !PARK_LEVEL_02;
    end else if (cmd.settle) begin
      clkByte02 <= PARK_LEVEL_02;
      clkByte13 <= !PARK_LEVEL_02;
    end else if (cmd.advance) begin
      clkByte02 <= !clkByte02;
      clkByte13 <= !clkByte13;
    end
  end

endmodule

// File: rtl/split_byte_clk.sv
module split_byte_clk
  import split_byte_clk_pkg::*;
#(
  parameter int GAP_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic tenBitMode,
  input  logic wordStb,
  input  logic slip,
  output logic clkByte02,
  output logic clkByte13
);

  phase_cmd_t phaseCmd;

  split_byte_clk_ctrl #(
    .GAP_CYCLES(GAP_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tenBitMode (tenBitMode),
    .wordStb    (wordStb),
    .slip       (slip),
    .phaseHigh  (clkByte02),
    .cmd        (phaseCmd)
  );

  split_byte_clk_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (phaseCmd),
    .clkByte02 (clkByte02),
    .clkByte13 (clkByte13)
  );

endmodule

// File: rtl/split_byte_clk_chk.sv
module split_byte_clk_chk #(
  parameter int GAP_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic tenBitMode,
  input logic wordStb,
  input logic slip,
  input logic clkByte02,
  input logic clkByte13
);

  localparam int RUN_W = $clog2(GAP_CYCLES + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(GAP_CYCLES);

  logic             prev02;
  logic [RUN_W-1:0] runLen;

  // Length of the level that clkByte02 held before its latest change.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prev02 <= 1'b0;
      runLen <= RUN_MAX;
    end else begin
      prev02 <= clkByte02;
      if (clkByte02 != prev02) begin
        runLen <= RUN_W'(1);
      end else if (runLen < RUN_MAX) begin
        runLen <= runLen + RUN_W'(1);
      end
    end
  end

  // R2: the two clocks stay complementary
  p_complement_r2: assert property (@(posedge clk) disable iff (!rstN)
    clkByte13 == !clkByte02);

  // R4: no phase ends before the guard length
  p_min_phase_r4: assert property (@(posedge clk) disable iff (!rstN)
    (clkByte02 != prev02) |-> (runLen >= RUN_MAX));

  // R5: a slip edge never moves the clocks
  p_slip_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (tenBitMode && slip) |=> $stable(clkByte02));

  // R6: once parked low outside 10-bit mode, stays parked whatever the strobe
  p_park_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!tenBitMode && !clkByte02) |=> !clkByte02);

  // R3: an accepted strobe with the guard met flips the clock
  p_strobe_flip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tenBitMode && wordStb && !slip && (runLen >= RUN_MAX) && (clkByte02 == prev02))
      |=> (clkByte02 != $past(clkByte02)));

endmodule

bind split_byte_clk split_byte_clk_chk #(
  .GAP_CYCLES(GAP_CYCLES)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .tenBitMode (tenBitMode),
  .wordStb    (wordStb),
  .slip       (slip),
  .clkByte02  (clkByte02),
  .clkByte13  (clkByte13)
);

// File: tb/split_byte_clk_tb.sv
module split_byte_clk_tb;

  localparam int GAP = 3;

  logic clk = 1'b0;
  logic rstN;
  logic tenBitMode;
  logic wordStb;
  logic slip;
  logic clkByte02;
  logic clkByte13;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  // Expected-state bookkeeping, written from the requirements.
  int  edgeIdx;
  int  lastEdge;
  bit  expHigh;
  bit  expPend;

  // Observed-run monitor for R4.
  int  runLen;
  bit  monPrev;
  bit  monOn = 1'b0;

  always #5 clk = ~clk;

  split_byte_clk #(.GAP_CYCLES(GAP)) u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .tenBitMode (tenBitMode),
    .wordStb    (wordStb),
    .slip       (slip),
    .clkByte02  (clkByte02),
    .clkByte13  (clkByte13)
  );

  task automatic check(input bit cond, input string req, input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, edgeIdx);
    end
  endtask

  // One fast-clock cycle: drive, advance the expectation at the edge, then compare.
  task automatic step(input bit m, input bit s, input bit sl, input string req);
    bit guardOk, want, flip;
    tenBitMode = m;
    wordStb    = s;
    slip       = sl;
    @(posedge clk);
    guardOk = (edgeIdx - lastEdge) >= GAP;
    want    = m && !sl && (s || expPend);
    flip    = guardOk && (want || (!m && expHigh));
    if (!m || sl)            expPend = 1'b0;
    else if (want && !guardOk) expPend = 1'b1;
    else if (flip)           expPend = 1'b0;
    if (flip) begin
      expHigh  = !expHigh;
      lastEdge = edgeIdx;
    end
    edgeIdx++;
    #1;
    check(clkByte02 == expHigh, req, clkByte02, expHigh);
    check(clkByte13 == !expHigh, "R2", clkByte13, !expHigh);
  endtask

  // R4 monitor: every observed level must last at least GAP cycles.
  always @(negedge clk) begin
    if (monOn) begin
      if (clkByte02 != monPrev) begin
        check(runLen >= GAP, "R4", runLen, GAP);
        runLen = 1;
      end else begin
        runLen++;
      end
      monPrev = clkByte02;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rstN = 1'b0; tenBitMode = 1'b1; wordStb = 1'b1; slip = 1'b0;
    edgeIdx = 0; lastEdge = -GAP; expHigh = 1'b0; expPend = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(clkByte02 == 1'b0, "R1", clkByte02, 0);
    check(clkByte13 == 1'b1, "R1", clkByte13, 1);
    wordStb = 1'b0;
    rstN    = 1'b1;
    check(clkByte02 == 1'b0, "R1", clkByte02, 0);
    monPrev = 1'b0; runLen = GAP; monOn = 1'b1;

    // R7: first accepted strobe after reset raises the 02 clock.
    step(1, 1, 0, "R7");
    check(clkByte02 == 1'b1, "R7", clkByte02, 1);

    // Spacing sweep: R3 for spacings at or above the guard, R4 below it.
    for (int p = 1; p <= 7; p++) begin
      for (int k = 0; k < 14; k++) begin
        step(1, 1, 0, (p >= GAP) ? "R3" : "R4");
        for (int j = 1; j < p; j++) step(1, 0, 0, (p >= GAP) ? "R3" : "R4");
      end
      for (int j = 0; j < GAP + 1; j++) step(1, 0, 0, "R4");
    end

    // R5: pending toggle built by an early strobe is cancelled by a slip.
    for (int j = 0; j < GAP; j++) step(1, 0, 0, "R5");
    step(1, 1, 0, "R5");
    step(1, 1, 0, "R5");
    step(1, 0, 1, "R5");
    for (int j = 0; j < GAP + 2; j++) step(1, 0, 0, "R5");
    // strobe that coincides with slip is ignored
    step(1, 1, 1, "R5");
    step(1, 0, 0, "R5");

    // R6: leave 10-bit mode with strobes still arriving; clocks park.
    for (int j = 0; j < 4 * GAP; j++) step(0, j[0], 0, "R6");
    check(clkByte02 == 1'b0, "R6", clkByte02, 0);
    check(clkByte13 == 1'b1, "R6", clkByte13, 1);
    step(1, 1, 0, "R7");
    check(clkByte02 == 1'b1, "R7", clkByte02, 1);

    // Mixed stretch: strobes, slips and mode changes from a shift register.
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      step(|lfsr[2:0], lfsr[5], lfsr[9] & lfsr[7], "R5");
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule